// File: doc/BRIEF.md
# Three-Wire Configuration Register Slave for a Dual-Channel Converter

This block is the serial configuration port of a two-channel converter. An external master lowers chip select, clocks in a 16-bit command word and then moves whole data bytes over one shared data pin. The command word holds a direction flag, a two-bit byte-count code and a 13-bit start register address. Each further data byte goes to the next register address.

The block keeps one register bank per channel. A channel-select register sits at one address that both channels share. It decides which banks a write reaches: channel A, channel B, both or neither. Reads always come from channel A's bank, and the channel-select register reads back at its own address. The serial pins are resynchronised into the system clock domain before use. Every serial event therefore takes effect a fixed number of system clocks after the pin changes.

Top module: `spi_cfg_slave`

## Requirements
- R1: After a synchronous reset, the data-pin output enable is low, every register of both banks is 0x00 and the channel-select value is 2'b11.
- R2: While chip select is low, the block samples the data pin on each rising serial clock edge. The first 16 bits, MSB first, form the command: bit 15 is the direction (1 = read), bits 14:13 are the byte-count code, and bits 12:0 are the start address.
- R3: In a write, each data byte is taken MSB first. It is written to the current address only after its eighth bit arrives, and with the channel-select value 2'b11 it lands in both banks.
- R4: Byte-count code 0, 1 and 2 allow 1, 2 and 3 data bytes. Later write bytes are ignored and later read bytes return 0x00. Code 3 streams bytes until chip select rises.
- R5: The address starts at the command's start address and rises by one for each further data byte, wrapping at 13 bits.
- R6: The channel-select register sits at address 0x010 and is shared by both channels. Bit 0 enables writes to bank A and bit 1 enables writes to bank B. Its write always takes effect, and a read of it returns {6'b0, select}.
- R7: A read returns bank A's contents MSB first. The first bit is driven on the first falling serial clock edge after the sixteenth command bit, and each later falling edge drives one new bit.
- R8: The output enable goes high on that first falling edge of a read and stays high until chip select rises. It is low at every other time, and a read changes no register.
- R9: Chip select rising at any point aborts the transfer. A partial data byte is discarded and the next transfer begins with a fresh command word.
- R10: A write to an address that is neither the channel-select address nor below 16 changes nothing, and a read of such an address returns 0x00.
- R11: Each serial pin passes through two synchroniser flops, so a pin edge takes effect on the third rising system clock edge after it.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn_i | input | 1 | Chip select, active low |
| spi_sclk_i | input | 1 | Serial clock from the master |
| spi_sdio_i | input | 1 | Data pin, input side |
| spi_sdio_o | output | 1 | Data pin, output side |
| spi_sdio_oe_o | output | 1 | Data pin drive enable (1 = slave drives) |
| chan_en_o | output | 2 | Channel-select value, bit 0 = A, bit 1 = B |
| cfg_a_o | output | 128 | Bank A registers, register n at bits 8n+7:8n |
| cfg_b_o | output | 128 | Bank B registers, same layout |

## Verification
Every pin change takes effect on the third rising system clock edge after the bench drives it: two synchroniser stages, then the state update. This covers a register commit after a byte's eighth rising edge, a new output bit after a falling edge, and the output enable dropping after chip select rises. The bench drives each pin change on a falling system clock edge. It applies the same change to its behavioural model exactly three rising edges later, then compares the output enable, the driven bit, both banks and the channel-select value on every falling edge. Each serial half-period lasts longer than that latency, so the master-side sample of the data pin taken just before a rising serial clock edge always sees the bit driven by the previous falling edge.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int ADDR_W = 13;
    localparam int BYTE_W = 8;
    localparam int CMD_W  = 16;
    localparam int NUM_CH = 2;

    localparam logic [1:0] LEN_STREAM = 2'b11;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    // Command word layout, MSB first on the wire
    typedef struct packed {
        logic              rd;
        logic [1:0]        len;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
        return cmd_t'(w);
    endfunction

    // True when byte number idx (0-based) lies inside the length code
    function automatic logic byte_allowed(input logic [1:0] len, input logic [1:0] idx);
        return (len == LEN_STREAM) || (idx <= len);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output wr_req_t           wr_o,
    output logic              sdo_o,
    output logic              oe_o,
    output logic              rd_mode_o
);

    logic sclk_prev_q;
    logic rise, fall;

    phase_e            phase_q;
    cmd_t              cmd_q;
    logic [CMD_W-2:0]  cmd_sr_q;
    logic [3:0]        cmd_cnt_q;
    logic [BYTE_W-2:0] rx_sr_q;
    logic [2:0]        rx_bit_q;
    logic [1:0]        rx_bytes_q;
    logic [ADDR_W-1:0] wr_addr_q;

    logic [BYTE_W-1:0] tx_sr_q;
    logic [2:0]        tx_bit_q;
    logic [1:0]        tx_idx_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              sdo_q, oe_q;

    logic [CMD_W-1:0]  cmd_word;
    cmd_t              cmd_new;
    logic              cmd_done, byte_done, last_byte;

    assign rise = sclk_s & ~sclk_prev_q;
    assign fall = ~sclk_s & sclk_prev_q;

    assign cmd_word  = {cmd_sr_q, sdi_s};
    assign cmd_new   = unpack_cmd(cmd_word);
    assign cmd_done  = rise && (phase_q == PH_CMD) && (cmd_cnt_q == 4'd15);
    assign byte_done = rise && (phase_q == PH_DATA) && (rx_bit_q == 3'd7);
    assign last_byte = (cmd_q.len != LEN_STREAM) && (rx_bytes_q == cmd_q.len);

    // Only one read port: the command end and a byte reload never coincide
    assign rd_addr_o = cmd_done ? cmd_new.addr : rd_addr_q;

    assign wr_o.valid = byte_done && !cmd_q.rd;
    assign wr_o.addr  = wr_addr_q;
    assign wr_o.data  = {rx_sr_q, sdi_s};

    always_ff @(posedge clk) begin
        if (rst) sclk_prev_q <= 1'b0;
        else     sclk_prev_q <= sclk_s;
    end

    // Receive side: command shift, data bytes, write address, byte count
    always_ff @(posedge clk) begin
        if (rst || csn_s) begin
            phase_q    <= PH_CMD;
            cmd_q      <= '0;
            cmd_sr_q   <= '0;
            cmd_cnt_q  <= '0;
            rx_sr_q    <= '0;
            rx_bit_q   <= '0;
            rx_bytes_q <= '0;
            wr_addr_q  <= '0;
        end else if (rise) begin
            unique case (phase_q)
                PH_CMD: begin
                    cmd_sr_q  <= cmd_word[CMD_W-2:0];
                    cmd_cnt_q <= cmd_cnt_q + 4'd1;
                    if (cmd_cnt_q == 4'd15) begin
                        cmd_q      <= cmd_new;
                        phase_q    <= PH_DATA;
                        wr_addr_q  <= cmd_new.addr;
                        rx_bit_q   <= '0;
                        rx_bytes_q <= '0;
                    end
                end
                PH_DATA: begin
                    rx_sr_q  <= {rx_sr_q[BYTE_W-3:0], sdi_s};
                    rx_bit_q <= rx_bit_q + 3'd1;
                    if (rx_bit_q == 3'd7) begin
                        wr_addr_q <= wr_addr_q + ADDR_W'(1);
                        if (last_byte)
                            phase_q <= PH_DONE;
                        else if (cmd_q.len != LEN_STREAM)
                            rx_bytes_q <= rx_bytes_q + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Transmit side: prefetch at command end, shift on falling edges
    always_ff @(posedge clk) begin
        if (rst || csn_s) begin
            tx_sr_q   <= '0;
            tx_bit_q  <= '0;
            tx_idx_q  <= '0;
            rd_addr_q <= '0;
            sdo_q     <= 1'b0;
            oe_q      <= 1'b0;
        end else if (cmd_done) begin
            tx_sr_q   <= rd_data_i;
            tx_bit_q  <= '0;
            tx_idx_q  <= '0;
            rd_addr_q <= cmd_new.addr + ADDR_W'(1);
        end else if (fall && (phase_q != PH_CMD) && cmd_q.rd) begin
            oe_q     <= 1'b1;
            sdo_q    <= tx_sr_q[BYTE_W-1];
            tx_bit_q <= tx_bit_q + 3'd1;
            if (tx_bit_q == 3'd7) begin
                if (byte_allowed(cmd_q.len, tx_idx_q + 2'd1) &&
                    !(cmd_q.len != LEN_STREAM && tx_idx_q == cmd_q.len)) begin
                    tx_sr_q   <= rd_data_i;
                    rd_addr_q <= rd_addr_q + ADDR_W'(1);
                    if (cmd_q.len != LEN_STREAM)
                        tx_idx_q <= tx_idx_q + 2'd1;
                end else begin
                    tx_sr_q <= '0;
                end
            end else begin
                tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign sdo_o     = sdo_q;
    assign oe_o      = oe_q;
    assign rd_mode_o = cmd_q.rd;

endmodule

// File: rtl/spi_reg_banks.sv
module spi_reg_banks
    import spi_cfg_pkg::*;
#(
    parameter int                NUM_REGS      = 16,
    parameter logic [ADDR_W-1:0] CHAN_IDX_ADDR = 13'h0010
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wr_req_t                    wr_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [BYTE_W-1:0]          rd_data_o,
    output logic [NUM_CH-1:0]          chan_en_o,
    output logic [NUM_REGS*BYTE_W-1:0] bank_a_o,
    output logic [NUM_REGS*BYTE_W-1:0] bank_b_o
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_CH-1:0]                         chan_en_q;
    logic [NUM_CH-1:0][NUM_REGS*BYTE_W-1:0]    bank_flat;
    logic [NUM_REGS-1:0][BYTE_W-1:0]           a_view;
    logic                                      wr_hit, wr_sel;
    logic [IDX_W-1:0]                          wr_idx, rd_idx;

    assign wr_hit = wr_i.valid && (wr_i.addr < ADDR_W'(NUM_REGS));
    assign wr_sel = wr_i.valid && (wr_i.addr == CHAN_IDX_ADDR);
    assign wr_idx = wr_i.addr[IDX_W-1:0];
    assign rd_idx = rd_addr_i[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)         chan_en_q <= '1;
        else if (wr_sel) chan_en_q <= wr_i.data[NUM_CH-1:0];
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bank
        logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;
        always_ff @(posedge clk) begin
            if (rst)
                regs_q <= '0;
            else if (wr_hit && chan_en_q[ch])
                regs_q[wr_idx] <= wr_i.data;
        end
        assign bank_flat[ch] = regs_q;
    end

    // Reads are served from channel A only
    assign a_view = bank_flat[0];

    always_comb begin
        if (rd_addr_i == CHAN_IDX_ADDR)
            rd_data_o = {{(BYTE_W-NUM_CH){1'b0}}, chan_en_q};
        else if (rd_addr_i < ADDR_W'(NUM_REGS))
            rd_data_o = a_view[rd_idx];
        else
            rd_data_o = '0;
    end

    assign chan_en_o = chan_en_q;
    assign bank_a_o  = bank_flat[0];
    assign bank_b_o  = bank_flat[1];

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int                SYNC_STAGES   = 2,
    parameter int                NUM_REGS      = 16,
    parameter logic [ADDR_W-1:0] CHAN_IDX_ADDR = 13'h0010
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       spi_csn_i,
    input  logic                       spi_sclk_i,
    input  logic                       spi_sdio_i,
    output logic                       spi_sdio_o,
    output logic                       spi_sdio_oe_o,
    output logic [NUM_CH-1:0]          chan_en_o,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_a_o,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_b_o
);

    logic [2:0]        pins_s;
    logic              csn_s, sclk_s, sdi_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_data;
    wr_req_t           wr_req;
    logic              wr_valid;
    logic              rd_mode;

    spi_pin_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (3),
        .RST_VAL (3'b001)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i ({spi_sdio_i, spi_sclk_i, spi_csn_i}),
        .q_o (pins_s)
    );

    assign {sdi_s, sclk_s, csn_s} = pins_s;

    spi_frame_ctrl frame_i (
        .clk       (clk),
        .rst       (rst),
        .csn_s     (csn_s),
        .sclk_s    (sclk_s),
        .sdi_s     (sdi_s),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_o      (wr_req),
        .sdo_o     (spi_sdio_o),
        .oe_o      (spi_sdio_oe_o),
        .rd_mode_o (rd_mode)
    );

    assign wr_valid = wr_req.valid;

    spi_reg_banks #(
        .NUM_REGS      (NUM_REGS),
        .CHAN_IDX_ADDR (CHAN_IDX_ADDR)
    ) banks_i (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr_req),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .chan_en_o (chan_en_o),
        .bank_a_o  (cfg_a_o),
        .bank_b_o  (cfg_b_o)
    );

endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk #(
    parameter int VW = 128
) (
    input logic          clk,
    input logic          rst,
    input logic          csn_s,
    input logic          rd_mode,
    input logic          wr_valid,
    input logic          oe,
    input logic [1:0]    chan_en,
    input logic [VW-1:0] cfg_a,
    input logic [VW-1:0] cfg_b
);

    // R1
    chan_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chan_en == 2'b11));

    // R8
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> !oe);

    // R8
    oe_read_only_chk: assert property (@(posedge clk) disable iff (rst)
        oe |-> rd_mode);

    // R8
    read_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        rd_mode |=> ($stable(cfg_a) && $stable(cfg_b)));

    // R3
    commit_on_byte_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> ($stable(cfg_a) && $stable(cfg_b) && $stable(chan_en)));

    // R6
    bank_b_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && chan_en == 2'b01) |=> $stable(cfg_b));

    // R6
    bank_a_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && chan_en == 2'b10) |=> $stable(cfg_a));

endmodule

bind spi_cfg_slave spi_cfg_slave_chk #(.VW(NUM_REGS*8)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .csn_s    (csn_s),
    .rd_mode  (rd_mode),
    .wr_valid (wr_valid),
    .oe       (spi_sdio_oe_o),
    .chan_en  (chan_en_o),
    .cfg_a    (cfg_a_o),
    .cfg_b    (cfg_b_o)
);

// File: tb/spi_cfg_slave_tb_top.sv
module spi_cfg_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;   // R11: two sync stages plus the state flop
    localparam int NREG       = 16;
    localparam int SEL_ADDR   = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csn = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, oe;
    logic [1:0] chan;
    logic [NREG*8-1:0] cfg_a, cfg_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit live = 0;

    // Behavioural model state
    int ma [NREG];
    int mb [NREG];
    int msel;
    int ph, hc, hw, mrdf, mlen, maddr, waddr, rxb, rxv, nbytes, fidx;
    int exp_oe, exp_sdo;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cfg_slave dut_i (
        .clk           (clk),
        .rst           (rst),
        .spi_csn_i     (csn),
        .spi_sclk_i    (sclk),
        .spi_sdio_i    (sdi),
        .spi_sdio_o    (sdo),
        .spi_sdio_oe_o (oe),
        .chan_en_o     (chan),
        .cfg_a_o       (cfg_a),
        .cfg_b_o       (cfg_b)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int mrd(input int a);
        if (a == SEL_ADDR) return msel;
        if (a < NREG) return ma[a];
        return 0;
    endfunction

    function automatic int mbyte(input int k);
        if (mlen == 3 || k <= mlen) return mrd((maddr + k) & 8191);
        return 0;
    endfunction

    task automatic m_abort();
        ph = 0; hc = 0; hw = 0; mrdf = 0; fidx = 0; exp_oe = 0; exp_sdo = 0;
    endtask

    task automatic m_rise(input bit b);
        if (ph == 0) begin
            hw = ((hw << 1) | b) & 16'hffff;
            hc++;
            if (hc == 16) begin
                mrdf = (hw >> 15) & 1; mlen = (hw >> 13) & 3; maddr = hw & 8191;
                waddr = maddr; ph = 1; rxb = 0; rxv = 0; nbytes = 0; fidx = 0;
            end
        end else if (ph == 1) begin
            rxv = ((rxv << 1) | b) & 255;
            rxb++;
            if (rxb == 8) begin
                rxb = 0;
                if (!mrdf) begin
                    if (waddr == SEL_ADDR) msel = rxv & 3;
                    else if (waddr < NREG) begin
                        if (msel & 1) ma[waddr] = rxv;
                        if (msel & 2) mb[waddr] = rxv;
                    end
                end
                waddr = (waddr + 1) & 8191;
                if (mlen != 3 && nbytes == mlen) ph = 2;
                else nbytes++;
            end
        end
    endtask

    task automatic m_fall();
        if (ph != 0 && mrdf) begin
            exp_oe = 1;
            exp_sdo = (mbyte(fidx / 8) >> (7 - fidx % 8)) & 1;
            fidx++;
        end
    endtask

    // Per-clock comparison against the model, sampled on the falling clock edge
    always @(negedge clk) begin
        if (live && !rst) begin
            logic [NREG*8-1:0] ea, eb;
            for (int i = 0; i < NREG; i++) begin
                ea[i*8 +: 8] = ma[i][7:0];
                eb[i*8 +: 8] = mb[i][7:0];
            end
            chk("R8 per-clock output enable", 128'(oe), 128'(exp_oe[0]));
            if (exp_oe != 0) chk("R7 per-clock driven bit", 128'(sdo), 128'(exp_sdo[0]));
            chk("R3 per-clock bank A", 128'(cfg_a), 128'(ea));
            chk("R6 per-clock bank B", 128'(cfg_b), 128'(eb));
            chk("R6 per-clock channel select", 128'(chan), 128'(msel[1:0]));
        end
    end

    task automatic wait_lat();
        repeat (LAT) @(posedge clk);
        #1;
    endtask

    task automatic set_cs(input bit v);
        @(negedge clk);
        csn = v;
        wait_lat();
        if (v) m_abort();
        @(negedge clk);
    endtask

    task automatic bit_xfer(input bit b, output bit got);
        @(negedge clk);
        if (sclk) begin
            sclk = 1'b0; sdi = b;
            wait_lat();
            m_fall();
        end else begin
            sdi = b;
        end
        repeat (2) @(negedge clk);
        got = sdo;
        sclk = 1'b1;
        wait_lat();
        m_rise(b);
    endtask

    task automatic byte_xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            bit g;
            bit_xfer(tx[i], g);
            rx[i] = g;
        end
    endtask

    task automatic end_frame();
        @(negedge clk);
        if (sclk) begin
            sclk = 1'b0;
            wait_lat();
            m_fall();
        end
        set_cs(1'b1);
    endtask

    task automatic command(input bit rd, input logic [1:0] len, input logic [12:0] addr);
        logic [15:0] w;
        logic [7:0] dummy;
        w = {rd, len, addr};
        set_cs(1'b0);
        byte_xfer(w[15:8], dummy);
        byte_xfer(w[7:0], dummy);
    endtask

    task automatic wr1(input logic [12:0] addr, input logic [7:0] d);
        logic [7:0] r;
        command(1'b0, 2'b00, addr);
        byte_xfer(d, r);
        end_frame();
    endtask

    initial begin
        logic [7:0] r0, r1, r2;
        for (int i = 0; i < NREG; i++) begin ma[i] = 0; mb[i] = 0; end
        msel = 3;
        m_abort();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        live = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 output enable after reset", 128'(oe), 128'(0));
        chk("R1 bank A after reset", 128'(cfg_a), 128'(0));
        chk("R1 bank B after reset", 128'(cfg_b), 128'(0));
        chk("R1 channel select after reset", 128'(chan), 128'(2'b11));

        // R2 R3 single byte to both banks
        wr1(13'd3, 8'hA5);
        chk("R3 bank A reg3", 128'(cfg_a[3*8 +: 8]), 128'(8'hA5));
        chk("R3 bank B reg3 broadcast", 128'(cfg_b[3*8 +: 8]), 128'(8'hA5));

        // R4 R5 length code 2 (three bytes), fourth byte ignored
        command(1'b0, 2'b10, 13'd5);
        byte_xfer(8'h11, r0); byte_xfer(8'h22, r0);
        byte_xfer(8'h33, r0); byte_xfer(8'h44, r0);
        end_frame();
        chk("R5 reg6 after auto-increment", 128'(cfg_a[6*8 +: 8]), 128'(8'h22));
        chk("R5 reg7 after auto-increment", 128'(cfg_a[7*8 +: 8]), 128'(8'h33));
        chk("R4 reg8 untouched past length", 128'(cfg_a[8*8 +: 8]), 128'(8'h00));

        // R4 streaming code
        command(1'b0, 2'b11, 13'd10);
        for (int k = 0; k < 5; k++) byte_xfer(8'(8'h10 + k), r0);
        end_frame();
        chk("R4 stream reg14", 128'(cfg_b[14*8 +: 8]), 128'(8'h14));

        // R6 channel steering
        wr1(13'h010, 8'h01);
        wr1(13'd2, 8'h5A);
        chk("R6 bank A only write A", 128'(cfg_a[2*8 +: 8]), 128'(8'h5A));
        chk("R6 bank A only leaves B", 128'(cfg_b[2*8 +: 8]), 128'(8'h00));
        wr1(13'h010, 8'h02);
        wr1(13'd2, 8'hC3);
        chk("R6 bank B only write B", 128'(cfg_b[2*8 +: 8]), 128'(8'hC3));
        chk("R6 bank B only leaves A", 128'(cfg_a[2*8 +: 8]), 128'(8'h5A));
        wr1(13'h010, 8'h00);
        wr1(13'd2, 8'hFF);
        chk("R6 no channel leaves A", 128'(cfg_a[2*8 +: 8]), 128'(8'h5A));
        wr1(13'h010, 8'hFF);
        chk("R6 select keeps two bits", 128'(chan), 128'(2'b11));

        // R7 read from bank A with auto-increment
        command(1'b1, 2'b01, 13'd2);
        byte_xfer(8'h00, r0); byte_xfer(8'h00, r1);
        end_frame();
        chk("R7 read byte0 from bank A", 128'(r0), 128'(8'h5A));
        chk("R7 read byte1 next address", 128'(r1), 128'(8'hA5));
        chk("R8 enable released after read", 128'(oe), 128'(0));

        // R6 R4 read select register, extra byte reads zero
        command(1'b1, 2'b00, 13'h010);
        byte_xfer(8'h00, r0); byte_xfer(8'h00, r1);
        end_frame();
        chk("R6 read select register", 128'(r0), 128'(8'h03));
        chk("R4 read past length is zero", 128'(r1), 128'(8'h00));

        // R5 streamed read across registers
        command(1'b1, 2'b11, 13'd14);
        byte_xfer(8'h00, r0); byte_xfer(8'h00, r1); byte_xfer(8'h00, r2);
        end_frame();
        chk("R5 stream read reg14", 128'(r0), 128'(8'h14));
        chk("R5 stream read reg15", 128'(r1), 128'(8'h00));
        chk("R5 stream read select address", 128'(r2), 128'(8'h03));

        // R9 abort mid-byte
        command(1'b0, 2'b00, 13'd4);
        for (int i = 0; i < 5; i++) begin
            bit g;
            bit_xfer(1'b1, g);
        end
        end_frame();
        chk("R9 partial byte discarded", 128'(cfg_a[4*8 +: 8]), 128'(8'h00));
        wr1(13'd4, 8'h77);
        chk("R9 fresh transfer after abort", 128'(cfg_a[4*8 +: 8]), 128'(8'h77));

        // R10 out-of-range address
        wr1(13'h100, 8'hEE);
        command(1'b1, 2'b00, 13'h100);
        byte_xfer(8'h00, r0);
        end_frame();
        chk("R10 out-of-range read zero", 128'(r0), 128'(8'h00));
        chk("R10 reg0 untouched", 128'(cfg_a[7:0]), 128'(8'h00));

        repeat (10) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule